// File: doc/BRIEF.md
# Multi-Source Reset Controller with Masking

The block gathers fourteen independent reset-request lines and turns them into one system reset output. Each line first passes through a two-flop synchronizer. It is then qualified by a per-source mask bit and interpreted according to a per-source trigger-mode bit. In level mode, the system reset follows the request for as long as the request stays high. In edge mode, each rising request produces one reset pulse of fixed length, and a request that stays high causes no further pulses. A reset-cause status register records which sources caused a reset. A sticky boot-release output lets a core leave reset once, and software cannot clear it afterwards.

Software reaches the block through a simple word register port with a write strobe, a two-bit address, write data and combinational read data. Each mask bit has its own lock bit. Once a lock bit is set, that lock bit and its mask bit can no longer change until power-on reset. An external configuration-lock input freezes the trigger-mode register. The active-low power-on reset initialises every register. An extra input tells whether that power-on came from the external pad.

The system reset is driven by a three-state machine:
- ST_IDLE: no reset.
- ST_PULSE: a fixed-length edge pulse is counting down.
- ST_HOLD: at least one level-mode source is active.

The transitions are:
- `go_hold`: any state moves to ST_HOLD while a level source is active. This has the highest priority.
- `go_pulse`: any state moves to ST_PULSE, reloading the counter, when an edge source rises.
- `stay_pulse`: ST_PULSE stays in ST_PULSE while the counter is not zero.
- `go_idle`: the state returns to ST_IDLE otherwise.

An edge that arrives while ST_HOLD is held by a level source is absorbed.

Top module: `sysrst_ctrl`

## Requirements
- R1: A request on `req_i` is synchronized through two flops. After the request rises, `sys_rst_o` goes high on the third rising clock edge. After a level-mode request falls, `sys_rst_o` goes low on the third rising clock edge.
- R2: For an unmasked level-mode source, `sys_rst_o` stays high for exactly as many cycles as the request was high.
- R3: For an unmasked edge-mode source, each rising request gives one `sys_rst_o` pulse of PULSE_LEN cycles (default 16), however long the request stays high. A second pulse needs the request to fall and rise again.
- R4: When mask bit k is 1, source k causes no reset and sets no status bit. The mask register is at address 2, and bit k (0..13) masks source k.
- R5: Bit 16+k of the mask register locks source k. While the lock bit is 1, writes change neither that lock bit nor mask bit k. Unlocked bits remain writable.
- R6: The trigger-mode register is at address 1. Bit k set to 1 selects edge mode for source k, and 0 selects level mode. While `cfg_lock_i` is 1, writes leave this register unchanged.
- R7: Bit 0 at address 0 drives `boot_release_o`. Writing 1 sets it, and no later write clears it.
- R8: The status register is at address 3. Bit k+1 is set when unmasked source k causes a reset. Writing 1 to a bit clears that bit and leaves the other bits unchanged. A new cause that arrives in the same cycle as a clear wins over the clear.
- R9: After power-on reset:
  - `sys_rst_o` is 0 and `boot_release_o` is 0.
  - The trigger-mode and mask registers are all 0.
  - In the status register, bit 0 is 1, bit 16 equals `por_pad_i`, and every other bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Active-low power-on reset, asynchronous |
| por_pad_i | input | 1 | Power-on came from the external pad, captured during reset |
| req_i | input | 14 | Asynchronous reset requests, one per source |
| cfg_lock_i | input | 1 | Freezes the trigger-mode register while high |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address (0 control, 1 mode, 2 mask, 3 status) |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational on address |
| sys_rst_o | output | 1 | System reset output |
| boot_release_o | output | 1 | Sticky core boot release |

## Verification
A request driven just after a falling edge reaches `sys_rst_o` and the status register three rising edges later. Two of those edges are spent in the synchronizer, and the state and status registers take the third. Register writes take effect on the single rising edge under the strobe. Read data is combinational, so it is sampled one time step after the address settles.

Pulse and hold lengths are checked without fixed sample points. The bench counts every cycle in which `sys_rst_o` is high over a window long enough to cover the three-edge lag and the whole pulse. The three-edge lag itself is checked separately, edge by edge, on both the rising and the falling request.

// File: rtl/sysrst_pkg.sv
package sysrst_pkg;
    localparam int NUM_SRC  = 14;
    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 2;
    localparam int LOCK_OFS = 16;
    localparam int PAD_BIT  = 16;

    typedef enum logic [ADDR_W-1:0] {
        RA_CTRL   = 2'd0,
        RA_MODE   = 2'd1,
        RA_MASK   = 2'd2,
        RA_STATUS = 2'd3
    } reg_addr_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PULSE = 2'd1,
        ST_HOLD  = 2'd2
    } rst_state_e;
endpackage

// File: rtl/sysrst_sync.sv
module sysrst_sync #(
    parameter int WIDTH = 14
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o,
    output logic [WIDTH-1:0] sync_prev_o
);
    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;
    logic [WIDTH-1:0] prev_q;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
            prev_q   <= '0;
        end else begin
            stage1_q <= async_i;
            stage2_q <= stage1_q;
            prev_q   <= stage2_q;
        end
    end

    assign sync_o      = stage2_q;
    assign sync_prev_o = prev_q;
endmodule

// File: rtl/sysrst_qual.sv
module sysrst_qual #(
    parameter int NUM_SRC = 14
) (
    input  logic [NUM_SRC-1:0] req_s_i,
    input  logic [NUM_SRC-1:0] req_prev_i,
    input  logic [NUM_SRC-1:0] mask_i,
    input  logic [NUM_SRC-1:0] edge_mode_i,
    output logic               level_hold_o,
    output logic               edge_fire_o,
    output logic [NUM_SRC-1:0] cause_o
);
    logic [NUM_SRC-1:0] lvl_act;
    logic [NUM_SRC-1:0] edg_act;

    for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
        always_comb begin
            lvl_act[k] = req_s_i[k] & ~mask_i[k] & ~edge_mode_i[k];
            edg_act[k] = req_s_i[k] & ~req_prev_i[k] & ~mask_i[k] & edge_mode_i[k];
        end
    end

    assign level_hold_o = |lvl_act;
    assign edge_fire_o  = |edg_act;
    assign cause_o      = lvl_act | edg_act;
endmodule

// File: rtl/sysrst_fsm.sv
module sysrst_fsm
    import sysrst_pkg::*;
#(
    parameter int PULSE_LEN = 16
) (
    input  logic clk,
    input  logic por_n,
    input  logic level_hold_i,
    input  logic edge_fire_i,
    output logic sys_rst_o
);
    localparam int CW = $clog2(PULSE_LEN + 1);

    rst_state_e    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = ST_IDLE;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE, ST_HOLD: begin
                if (level_hold_i) begin
                    state_d = ST_HOLD;
                end else if (edge_fire_i) begin
                    state_d = ST_PULSE;
                    cnt_d   = CW'(PULSE_LEN - 1);
                end else begin
                    state_d = ST_IDLE;
                end
            end
            ST_PULSE: begin
                if (level_hold_i) begin
                    state_d = ST_HOLD;
                end else if (edge_fire_i) begin
                    state_d = ST_PULSE;
                    cnt_d   = CW'(PULSE_LEN - 1);
                end else if (cnt_q != '0) begin
                    state_d = ST_PULSE;
                    cnt_d   = cnt_q - 1'b1;
                end else begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        sys_rst_o = (state_q != ST_IDLE);
    end

    // R2
    level_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
        level_hold_i |=> sys_rst_o);

    // R3
    edge_start_chk: assert property (@(posedge clk) disable iff (!por_n)
        (edge_fire_i && !level_hold_i) |=> (state_q == ST_PULSE));
endmodule

// File: rtl/sysrst_regs.sv
module sysrst_regs
    import sysrst_pkg::*;
#(
    parameter int NUM_SRC = 14
) (
    input  logic               clk,
    input  logic               por_n,
    input  logic               por_pad_i,
    input  logic               cfg_lock_i,
    input  logic               wr_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [DATA_W-1:0]  wdata_i,
    output logic [DATA_W-1:0]  rdata_o,
    input  logic [NUM_SRC-1:0] cause_i,
    output logic [NUM_SRC-1:0] mask_o,
    output logic [NUM_SRC-1:0] edge_mode_o,
    output logic               boot_o
);
    localparam int STAT_W = NUM_SRC + 1;

    logic [NUM_SRC-1:0] mask_q;
    logic [NUM_SRC-1:0] lock_q;
    logic [NUM_SRC-1:0] mode_q;
    logic [STAT_W-1:0]  stat_q;
    logic               pad_q;
    logic               boot_q;

    logic wr_ctrl, wr_mode, wr_mask, wr_stat;

    always_comb begin
        wr_ctrl = wr_i && (addr_i == RA_CTRL);
        wr_mode = wr_i && (addr_i == RA_MODE);
        wr_mask = wr_i && (addr_i == RA_MASK);
        wr_stat = wr_i && (addr_i == RA_STATUS);
    end

    for (genvar k = 0; k < NUM_SRC; k++) begin : g_mask
        always_ff @(posedge clk or negedge por_n) begin
            if (!por_n) begin
                mask_q[k] <= 1'b0;
                lock_q[k] <= 1'b0;
            end else if (wr_mask && !lock_q[k]) begin
                mask_q[k] <= wdata_i[k];
                lock_q[k] <= wdata_i[LOCK_OFS + k];
            end
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            mode_q <= '0;
        end else if (wr_mode && !cfg_lock_i) begin
            mode_q <= wdata_i[NUM_SRC-1:0];
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            boot_q <= 1'b0;
        end else if (wr_ctrl && wdata_i[0]) begin
            boot_q <= 1'b1;
        end
    end

    logic [STAT_W-1:0] stat_set, stat_clr;
    always_comb begin
        stat_set = {cause_i, 1'b0};
        stat_clr = wr_stat ? wdata_i[STAT_W-1:0] : '0;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            stat_q <= STAT_W'(1);
            pad_q  <= por_pad_i;
        end else begin
            stat_q <= (stat_q & ~stat_clr) | stat_set;
            if (wr_stat && wdata_i[PAD_BIT]) begin
                pad_q <= 1'b0;
            end
        end
    end

    always_comb begin
        rdata_o = '0;
        unique case (addr_i)
            RA_CTRL:   rdata_o[0] = boot_q;
            RA_MODE:   rdata_o[NUM_SRC-1:0] = mode_q;
            RA_MASK: begin
                rdata_o[NUM_SRC-1:0]                 = mask_q;
                rdata_o[LOCK_OFS+NUM_SRC-1:LOCK_OFS] = lock_q;
            end
            RA_STATUS: begin
                rdata_o[STAT_W-1:0] = stat_q;
                rdata_o[PAD_BIT]    = pad_q;
            end
            default: rdata_o = '0;
        endcase
    end

    assign mask_o      = mask_q;
    assign edge_mode_o = mode_q;
    assign boot_o      = boot_q;

    // R7
    boot_sticky_chk: assert property (@(posedge clk) disable iff (!por_n)
        boot_q |=> boot_q);

    // R5
    mask_lock_chk: assert property (@(posedge clk) disable iff (!por_n)
        1'b1 |=> (((mask_q ^ $past(mask_q)) & $past(lock_q)) == '0)
                 && ((lock_q & $past(lock_q)) == $past(lock_q)));

    // R6
    mode_frozen_chk: assert property (@(posedge clk) disable iff (!por_n)
        cfg_lock_i |=> $stable(mode_q));

    // R8
    cause_capture_chk: assert property (@(posedge clk) disable iff (!por_n)
        (|cause_i) |=> ((stat_q[STAT_W-1:1] & $past(cause_i)) == $past(cause_i)));
endmodule

// File: rtl/sysrst_ctrl.sv
module sysrst_ctrl
    import sysrst_pkg::*;
#(
    parameter int PULSE_LEN = 16
) (
    input  logic               clk,
    input  logic               por_n,
    input  logic               por_pad_i,
    input  logic [NUM_SRC-1:0] req_i,
    input  logic               cfg_lock_i,
    input  logic               reg_wr_i,
    input  logic [ADDR_W-1:0]  reg_addr_i,
    input  logic [DATA_W-1:0]  reg_wdata_i,
    output logic [DATA_W-1:0]  reg_rdata_o,
    output logic               sys_rst_o,
    output logic               boot_release_o
);
    logic [NUM_SRC-1:0] req_s, req_prev;
    logic [NUM_SRC-1:0] mask, edge_mode, cause;
    logic               level_hold, edge_fire;

    sysrst_sync #(.WIDTH(NUM_SRC)) u_sync (
        .clk         (clk),
        .por_n       (por_n),
        .async_i     (req_i),
        .sync_o      (req_s),
        .sync_prev_o (req_prev)
    );

    sysrst_qual #(.NUM_SRC(NUM_SRC)) u_qual (
        .req_s_i      (req_s),
        .req_prev_i   (req_prev),
        .mask_i       (mask),
        .edge_mode_i  (edge_mode),
        .level_hold_o (level_hold),
        .edge_fire_o  (edge_fire),
        .cause_o      (cause)
    );

    sysrst_fsm #(.PULSE_LEN(PULSE_LEN)) u_fsm (
        .clk          (clk),
        .por_n        (por_n),
        .level_hold_i (level_hold),
        .edge_fire_i  (edge_fire),
        .sys_rst_o    (sys_rst_o)
    );

    sysrst_regs #(.NUM_SRC(NUM_SRC)) u_regs (
        .clk         (clk),
        .por_n       (por_n),
        .por_pad_i   (por_pad_i),
        .cfg_lock_i  (cfg_lock_i),
        .wr_i        (reg_wr_i),
        .addr_i      (reg_addr_i),
        .wdata_i     (reg_wdata_i),
        .rdata_o     (reg_rdata_o),
        .cause_i     (cause),
        .mask_o      (mask),
        .edge_mode_o (edge_mode),
        .boot_o      (boot_release_o)
    );

    // R4
    masked_quiet_chk: assert property (@(posedge clk) disable iff (!por_n)
        ((req_s & ~mask) == '0) |=> !$rose(sys_rst_o));
endmodule

// File: tb/sim_sysrst_ctrl.sv
module sim_sysrst_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int PLEN = 16;
    localparam int NVEC = 8;

    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        por_pad = 1'b1;
    logic [13:0] req = '0;
    logic        cfg_lock = 1'b0;
    logic        wr = 1'b0;
    logic [1:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        sys_rst, boot;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sysrst_ctrl #(.PULSE_LEN(PLEN)) u0 (
        .clk(clk), .por_n(por_n), .por_pad_i(por_pad), .req_i(req),
        .cfg_lock_i(cfg_lock), .reg_wr_i(wr), .reg_addr_i(addr),
        .reg_wdata_i(wdata), .reg_rdata_o(rdata), .sys_rst_o(sys_rst),
        .boot_release_o(boot)
    );

    // vector fields: [15:12] source, [11] edge mode, [10] masked, [7:0] hold cycles
    localparam logic [15:0] VEC [NVEC] = '{
        {4'd0,  1'b0, 1'b0, 2'b0, 8'd5},
        {4'd13, 1'b0, 1'b0, 2'b0, 8'd9},
        {4'd2,  1'b1, 1'b0, 2'b0, 8'd3},
        {4'd7,  1'b1, 1'b0, 2'b0, 8'd40},
        {4'd5,  1'b0, 1'b1, 2'b0, 8'd6},
        {4'd9,  1'b1, 1'b1, 2'b0, 8'd4},
        {4'd11, 1'b1, 1'b0, 2'b0, 8'd1},
        {4'd4,  1'b0, 1'b0, 2'b0, 8'd1}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1;
        d = rdata;
    endtask

    // raise source for hold cycles, then count sys_rst high cycles over a window
    task automatic run_src(input int src, input int hold, input int tail, output int cnt);
        cnt = 0;
        @(negedge clk);
        req[src] = 1'b1;
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            if (sys_rst) cnt++;
        end
        req[src] = 1'b0;
        for (int i = 0; i < tail; i++) begin
            @(negedge clk);
            if (sys_rst) cnt++;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        int cnt;
        repeat (3) @(negedge clk);
        por_n = 1'b1;
        #1;
        // R9 reset state
        check("R9 sys_rst", {31'b0, sys_rst}, 32'd0);
        check("R9 boot", {31'b0, boot}, 32'd0);
        reg_read(2'd3, rd); check("R9 status", rd, 32'h0001_0001);
        reg_read(2'd1, rd); check("R9 mode", rd, 32'd0);
        reg_read(2'd2, rd); check("R9 mask", rd, 32'd0);

        // table walk: R2 R3 R4 R8
        for (int v = 0; v < NVEC; v++) begin
            int src, hold, expc;
            logic em, mk;
            src  = int'(VEC[v][15:12]);
            em   = VEC[v][11];
            mk   = VEC[v][10];
            hold = int'(VEC[v][7:0]);
            reg_write(2'd1, 32'(em) << src);
            reg_write(2'd2, 32'(mk) << src);
            reg_write(2'd3, 32'h0001_FFFF);
            run_src(src, hold, 40, cnt);
            expc = mk ? 0 : (em ? PLEN : hold);
            check($sformatf("R2/R3/R4 vec%0d reset cycles", v), 32'(cnt), 32'(expc));
            reg_read(2'd3, rd);
            check($sformatf("R8/R4 vec%0d status", v), rd, mk ? 32'd0 : (32'd1 << (src + 1)));
        end

        // R1 latency, level source 1
        reg_write(2'd1, 32'd0);
        reg_write(2'd2, 32'd0);
        @(negedge clk);
        req[1] = 1'b1;
        @(negedge clk); check("R1 rise edge1", {31'b0, sys_rst}, 32'd0);
        @(negedge clk); check("R1 rise edge2", {31'b0, sys_rst}, 32'd0);
        @(negedge clk); check("R1 rise edge3", {31'b0, sys_rst}, 32'd1);
        repeat (3) @(negedge clk);
        req[1] = 1'b0;
        @(negedge clk); check("R1 fall edge1", {31'b0, sys_rst}, 32'd1);
        @(negedge clk); check("R1 fall edge2", {31'b0, sys_rst}, 32'd1);
        @(negedge clk); check("R1 fall edge3", {31'b0, sys_rst}, 32'd0);

        // R3 re-fire needs drop and rise, source 6 edge
        reg_write(2'd1, 32'd1 << 6);
        reg_write(2'd3, 32'h0001_FFFF);
        run_src(6, 20, 5, cnt);
        begin
            int c2;
            run_src(6, 20, 30, c2);
            check("R3 two pulses", 32'(cnt + c2), 32'(2 * PLEN));
        end
        // R8 W1C keeps other bits
        reg_write(2'd1, 32'd0);
        run_src(0, 3, 10, cnt);
        reg_read(2'd3, rd); check("R8 two causes", rd, 32'h0000_0082);
        reg_write(2'd3, 32'h0000_0080);
        reg_read(2'd3, rd); check("R8 w1c partial", rd, 32'h0000_0002);

        // R7 boot release sticky
        reg_write(2'd0, 32'd1);
        check("R7 boot set", {31'b0, boot}, 32'd1);
        reg_write(2'd0, 32'd0);
        reg_read(2'd0, rd); check("R7 boot sticky", rd, 32'd1);
        check("R7 boot pin", {31'b0, boot}, 32'd1);

        // R6 config lock freezes mode
        reg_write(2'd1, 32'h0000_0005);
        reg_read(2'd1, rd); check("R6 mode write", rd, 32'h0000_0005);
        cfg_lock = 1'b1;
        reg_write(2'd1, 32'h0000_3FFF);
        reg_read(2'd1, rd); check("R6 mode frozen", rd, 32'h0000_0005);
        cfg_lock = 1'b0;
        reg_write(2'd1, 32'd0);

        // R5 mask lock
        reg_write(2'd2, 32'h0008_0008);
        reg_write(2'd2, 32'h0000_0000);
        reg_read(2'd2, rd); check("R5 lock holds", rd, 32'h0008_0008);
        reg_write(2'd2, 32'h0000_0011);
        reg_read(2'd2, rd); check("R5 others writable", rd, 32'h0008_0019);
        reg_write(2'd3, 32'h0001_FFFF);
        run_src(3, 6, 10, cnt);
        check("R5/R4 locked mask blocks", 32'(cnt), 32'd0);
        reg_read(2'd3, rd); check("R5/R4 status untouched", rd, 32'd0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule